// File: doc/BRIEF.md
# PC Card Attribute Configuration Register File

This block is the attribute-memory side of a card that presents an ATA disk over a PC Card or CompactFlash socket. The host reads and writes attribute space one byte at a time. Addresses below a configuration base fall in the card information structure. The bytes of that structure come from an external table through a lookup port. At and above the base there are four configuration registers: option, status, pin replacement and socket/copy.

The block also forms the card's interrupt request. The inputs to that request are the stored registers and two device-control bits driven by the task-file logic. A drive-interrupt level from the ATA engine is captured into the status register. The option register supplies the current addressing-mode field and a soft-reset level to the rest of the card.

Top module: `pccard_cfg_regs`

## Requirements
- R1: A read below the base address (0x200) returns the byte presented on `cis_data` for `cis_addr` = low address bits when the address is below CIS_LEN (default 330), and 0x00 from CIS_LEN up to the base. Read data appears on `attr_rdata` one clock after the request and holds until the next read.
- R2: A write to base+0 stores the written byte ANDed with 0xCF in the option register. `mode_o` shows option bits 5:0.
- R3: While option bit 7 is 1 the card is held in soft reset. `sreset_o` is high, and the status and pin registers read as cleared (status 0x00, pin 0x0C) even after writes to them or a high drive interrupt. Writing bit 7 back to 0 releases the hold.
- R4: A write to base+2 keeps status bits 7 and 1 and loads bits 6, 5, 4 and 2 from the value (mask 0x74). Status bits 3 and 0 always read 0.
- R5: A status write whose bit 2 differs from the stored bit 2 sets the card-ready flag (pin register bit 5). A write that leaves bit 2 unchanged does not set it.
- R6: A status read while `ctl_irq_dis` is 1 returns the stored status with bit 1 cleared.
- R7: A read of base+4 returns the ready flag in bit 5 ORed with 0x0C. A write there stores bit 1 of the value and never changes the ready flag.
- R8: Base+6 and every other undecoded offset at or above the base read 0x00. Writes to them change no register.
- R9: Status bit 1 follows the `drv_irq` level, one clock later.
- R10: `irq_o` is 1 only when status bit 1 is 0, `ctl_irq_dis` and `ctl_srst` are both 0, and option bit 7 is 0. It follows the control inputs without a clock.
- R11: Reset clears the option, status and pin registers and the read data: mode 0, `sreset_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| attr_req | input | 1 | Attribute access strobe, one cycle per access |
| attr_we | input | 1 | 1 = write, 0 = read |
| attr_addr | input | ADDR_W (12) | Attribute byte address |
| attr_wdata | input | 8 | Write byte |
| attr_rdata | output | 8 | Read byte, valid the cycle after a read |
| cis_addr | output | CIS_AW (9) | Lookup address into the external information table |
| cis_data | input | 8 | Table byte for `cis_addr` |
| drv_irq | input | 1 | Drive interrupt level from the ATA engine |
| ctl_irq_dis | input | 1 | Device-control interrupt-disable bit |
| ctl_srst | input | 1 | Device-control soft-reset bit |
| irq_o | output | 1 | Card interrupt request |
| sreset_o | output | 1 | Soft-reset hold level (option bit 7) |
| mode_o | output | 6 | Addressing-mode field (option bits 5:0) |

## Verification
Checked on every cycle: the stored register images never carry bits outside their write masks; the soft-reset hold keeps status and pin state cleared and forces the interrupt low; the device-control bits block the interrupt; status bit 1 tracks the drive level one clock later. A changed power-down bit must set the ready flag, and every socket/copy read, masked status read and pin read returns its fixed pattern. The scenarios alone show the full read values. These are the table bytes and the zero region up to the base, the exact masked images after each kind of write, and that writes to unknown offsets leave every register unchanged. They also show that the ready flag survives a pin write and that releasing soft reset restores the interrupt.

// File: rtl/pccfg_pkg.sv
package pccfg_pkg;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_CIS  = 3'd1,
        SEL_OPT  = 3'd2,
        SEL_STAT = 3'd3,
        SEL_PIN  = 3'd4,
        SEL_SOCK = 3'd5
    } cfg_sel_e;

    // register offsets from the configuration base
    localparam int OFF_OPT  = 0;
    localparam int OFF_STAT = 2;
    localparam int OFF_PIN  = 4;
    localparam int OFF_SOCK = 6;

    localparam logic [7:0] OPT_WMASK  = 8'hCF;
    localparam logic [7:0] STAT_KEEP  = 8'h82;
    localparam logic [7:0] STAT_LOAD  = 8'h74;
    localparam logic [7:0] PIN_RDY    = 8'h20;
    localparam logic [7:0] PIN_WMASK  = 8'h02;
    localparam logic [7:0] PIN_CONST  = 8'h0C;

    localparam int STAT_IRQ_BIT = 1;
    localparam int STAT_PWD_BIT = 2;
    localparam int PIN_RDY_BIT  = 5;
    localparam int OPT_SRST_BIT = 7;

    typedef struct packed {
        logic [7:0] opt;
        logic [7:0] stat;
        logic [7:0] pins;
    } cfg_state_t;

endpackage

// File: rtl/pccfg_decode.sv
module pccfg_decode
    import pccfg_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int CFG_BASE = 'h200,
    parameter int CIS_LEN  = 330
) (
    input  logic [ADDR_W-1:0] addr,
    output cfg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W:0]   CIS_LIM = (ADDR_W+1)'(CIS_LEN);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = addr - BASE_A;
        sel    = SEL_NONE;
        if (addr < BASE_A) begin
            if ({1'b0, addr} < CIS_LIM) begin
                sel = SEL_CIS;
            end
        end else begin
            case (offset)
                ADDR_W'(OFF_OPT):  sel = SEL_OPT;
                ADDR_W'(OFF_STAT): sel = SEL_STAT;
                ADDR_W'(OFF_PIN):  sel = SEL_PIN;
                ADDR_W'(OFF_SOCK): sel = SEL_SOCK;
                default:           sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pccfg_regs.sv
module pccfg_regs
    import pccfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  cfg_sel_e   sel,
    input  logic [7:0] wdata,
    input  logic       drv_irq,
    output logic [7:0] opt_q,
    output logic [7:0] stat_q,
    output logic       pin_rdy_q
);
    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stat[STAT_IRQ_BIT] = drv_irq;
        if (wr_en) begin
            case (sel)
                SEL_OPT: st_d.opt = wdata & OPT_WMASK;
                SEL_STAT: begin
                    st_d.stat = (st_q.stat & STAT_KEEP) | (wdata & STAT_LOAD);
                    st_d.stat[STAT_IRQ_BIT] = drv_irq;
                    if (st_q.stat[STAT_PWD_BIT] != wdata[STAT_PWD_BIT]) begin
                        st_d.pins[PIN_RDY_BIT] = 1'b1;
                    end
                end
                SEL_PIN: st_d.pins = (st_q.pins & PIN_RDY) | (wdata & PIN_WMASK);
                default: ;
            endcase
        end
        // soft-reset hold: status and pin state stay cleared
        if (st_d.opt[OPT_SRST_BIT]) begin
            st_d.stat = '0;
            st_d.pins = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign opt_q     = st_q.opt;
    assign stat_q    = st_q.stat;
    assign pin_rdy_q = st_q.pins[PIN_RDY_BIT];

    p_opt_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_q & ~OPT_WMASK) == 8'h00);

    p_hold_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        opt_q[OPT_SRST_BIT] |-> (stat_q == 8'h00 && !pin_rdy_q));

    p_stat_unused_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[3] == 1'b0) && (stat_q[0] == 1'b0));

    p_ready_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_STAT && !opt_q[OPT_SRST_BIT]
         && (stat_q[STAT_PWD_BIT] != wdata[STAT_PWD_BIT])) |=> pin_rdy_q);

    p_irq_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !opt_q[OPT_SRST_BIT]) |-> stat_q[STAT_IRQ_BIT] == $past(drv_irq));
endmodule

// File: rtl/pccfg_rdmux.sv
module pccfg_rdmux
    import pccfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  cfg_sel_e   sel,
    input  logic [7:0] opt,
    input  logic [7:0] stat,
    input  logic       pin_rdy,
    input  logic       irq_dis,
    input  logic [7:0] cis_data,
    output logic [7:0] rdata
);
    logic [7:0] val;
    logic [7:0] rdata_d, rdata_q;

    always_comb begin
        case (sel)
            SEL_CIS:  val = cis_data;
            SEL_OPT:  val = opt;
            SEL_STAT: val = irq_dis ? (stat & ~(8'h01 << STAT_IRQ_BIT)) : stat;
            SEL_PIN:  val = ({7'd0, pin_rdy} << PIN_RDY_BIT) | PIN_CONST;
            default:  val = 8'h00;
        endcase
        rdata_d = rd_en ? val : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= 8'h00;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    p_stat_hide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_STAT && irq_dis) |=> !rdata_q[STAT_IRQ_BIT]);

    p_pin_form_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_PIN) |=> (rdata_q & ~PIN_RDY) == PIN_CONST);

    p_sock_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_SOCK) |=> rdata_q == 8'h00);
endmodule

// File: rtl/pccfg_irq.sv
module pccfg_irq (
    input  logic stat_irq,
    input  logic opt_srst,
    input  logic ctl_irq_dis,
    input  logic ctl_srst,
    output logic irq
);
    // status flag is inverted with respect to the request line
    always_comb begin
        irq = ~stat_irq & ~ctl_irq_dis & ~ctl_srst & ~opt_srst;
    end
endmodule

// File: rtl/pccard_cfg_regs.sv
module pccard_cfg_regs
    import pccfg_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int CFG_BASE = 'h200,
    parameter int CIS_LEN  = 330,
    parameter int CIS_AW   = $clog2(CIS_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              attr_req,
    input  logic              attr_we,
    input  logic [ADDR_W-1:0] attr_addr,
    input  logic [7:0]        attr_wdata,
    output logic [7:0]        attr_rdata,
    output logic [CIS_AW-1:0] cis_addr,
    input  logic [7:0]        cis_data,
    input  logic              drv_irq,
    input  logic              ctl_irq_dis,
    input  logic              ctl_srst,
    output logic              irq_o,
    output logic              sreset_o,
    output logic [5:0]        mode_o
);
    cfg_sel_e   sel;
    logic       rd_en, wr_en;
    logic [7:0] opt_q, stat_q;
    logic       pin_rdy_q;

    assign rd_en    = attr_req & ~attr_we;
    assign wr_en    = attr_req & attr_we;
    assign cis_addr = attr_addr[CIS_AW-1:0];

    pccfg_decode #(
        .ADDR_W   (ADDR_W),
        .CFG_BASE (CFG_BASE),
        .CIS_LEN  (CIS_LEN)
    ) u_decode (
        .addr (attr_addr),
        .sel  (sel)
    );

    pccfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .sel       (sel),
        .wdata     (attr_wdata),
        .drv_irq   (drv_irq),
        .opt_q     (opt_q),
        .stat_q    (stat_q),
        .pin_rdy_q (pin_rdy_q)
    );

    pccfg_rdmux u_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .sel      (sel),
        .opt      (opt_q),
        .stat     (stat_q),
        .pin_rdy  (pin_rdy_q),
        .irq_dis  (ctl_irq_dis),
        .cis_data (cis_data),
        .rdata    (attr_rdata)
    );

    pccfg_irq u_irq (
        .stat_irq    (stat_q[STAT_IRQ_BIT]),
        .opt_srst    (opt_q[OPT_SRST_BIT]),
        .ctl_irq_dis (ctl_irq_dis),
        .ctl_srst    (ctl_srst),
        .irq         (irq_o)
    );

    assign sreset_o = opt_q[OPT_SRST_BIT];
    assign mode_o   = opt_q[5:0];

    p_irq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sreset_o |-> !irq_o);

    p_irq_ctl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_irq_dis || ctl_srst) |-> !irq_o);
endmodule

// File: tb/tb_pccard_cfg_regs.sv
`timescale 1ns/1ps
module tb_pccard_cfg_regs;
    localparam int ADDR_W  = 12;
    localparam int CIS_LEN = 330;
    localparam int CIS_AW  = 9;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              attr_req, attr_we;
    logic [ADDR_W-1:0] attr_addr;
    logic [7:0]        attr_wdata, attr_rdata;
    logic [CIS_AW-1:0] cis_addr;
    logic [7:0]        cis_data;
    logic              drv_irq, ctl_irq_dis, ctl_srst;
    logic              irq_o, sreset_o;
    logic [5:0]        mode_o;

    always #4 clk = ~clk;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    rd_item_t sb_q[$];
    int  n_vec = 0;
    int  n_bad = 0;
    bit  pend  = 1'b0;
    bit  done  = 1'b0;

    function automatic logic [7:0] cis_fn(input logic [CIS_AW-1:0] a);
        return a[7:0] ^ 8'h5A ^ {7'd0, a[8]};
    endfunction

    assign cis_data = cis_fn(cis_addr);

    pccard_cfg_regs dut (
        .clk (clk), .rst_n (rst_n),
        .attr_req (attr_req), .attr_we (attr_we), .attr_addr (attr_addr),
        .attr_wdata (attr_wdata), .attr_rdata (attr_rdata),
        .cis_addr (cis_addr), .cis_data (cis_data),
        .drv_irq (drv_irq), .ctl_irq_dis (ctl_irq_dis), .ctl_srst (ctl_srst),
        .irq_o (irq_o), .sreset_o (sreset_o), .mode_o (mode_o)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // driver: queue the expectation, then issue the read
    task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string tag);
        rd_item_t it;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        attr_req = 1'b1; attr_we = 1'b0; attr_addr = a;
        @(negedge clk);
        attr_req = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        attr_req = 1'b1; attr_we = 1'b1; attr_addr = a; attr_wdata = d;
        @(negedge clk);
        attr_req = 1'b0; attr_we = 1'b0;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    // monitor: a read issued at an edge is compared at the next falling edge
    always @(posedge clk) pend <= rst_n && attr_req && !attr_we;

    always @(negedge clk) begin
        rd_item_t it;
        if (pend) begin
            if (sb_q.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL scoreboard: got %02h expected no read", attr_rdata);
            end else begin
                it = sb_q.pop_front();
                check(it.tag, attr_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; attr_req = 1'b0; attr_we = 1'b0; attr_addr = '0;
        attr_wdata = '0; drv_irq = 1'b0; ctl_irq_dis = 1'b0; ctl_srst = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R11 reset state
        check("R11 mode", {2'b0, mode_o}, 8'h00);
        check("R11 sreset", {7'd0, sreset_o}, 8'h00);
        check("R11 rdata", attr_rdata, 8'h00);
        check("R10 irq after reset", {7'd0, irq_o}, 8'h01);
        rd(12'h200, 8'h00, "R11 option");
        rd(12'h202, 8'h00, "R11 status");
        rd(12'h204, 8'h0C, "R11 pin");

        // R1 information table region
        rd(12'h000, cis_fn(9'h000), "R1 table first");
        rd(12'h0A7, cis_fn(9'h0A7), "R1 table mid");
        rd(12'h149, cis_fn(9'h149), "R1 table last");
        rd(12'h14A, 8'h00, "R1 past length");
        rd(12'h1FF, 8'h00, "R1 below base");

        // R2 option masking and mode field
        wr(12'h200, 8'h7F);
        check("R2 mode", {2'b0, mode_o}, 8'h0F);
        rd(12'h200, 8'h4F, "R2 option masked");
        wr(12'h200, 8'h01);
        check("R2 mode 1", {2'b0, mode_o}, 8'h01);

        // R5 negative then R4/R5 positive
        wr(12'h202, 8'h70);
        rd(12'h202, 8'h70, "R4 status load");
        rd(12'h204, 8'h0C, "R5 no ready on same pwd");
        wr(12'h202, 8'hFF);
        rd(12'h202, 8'h74, "R4 status mask");
        rd(12'h204, 8'h2C, "R5 ready on pwd change");

        // R7 pin write keeps ready flag
        wr(12'h204, 8'h00);
        rd(12'h204, 8'h2C, "R7 ready kept");

        // R9 / R6 / R10 drive interrupt path
        @(negedge clk); drv_irq = 1'b1;
        idle(1);
        check("R10 irq low on flag", {7'd0, irq_o}, 8'h00);
        rd(12'h202, 8'h76, "R9 flag captured");
        ctl_irq_dis = 1'b1;
        rd(12'h202, 8'h74, "R6 flag hidden");
        @(negedge clk); drv_irq = 1'b0;
        idle(1);
        check("R10 blocked by disable", {7'd0, irq_o}, 8'h00);
        ctl_irq_dis = 1'b0; ctl_srst = 1'b1; #1;
        check("R10 blocked by ctl reset", {7'd0, irq_o}, 8'h00);
        ctl_srst = 1'b0; #1;
        check("R10 asserted", {7'd0, irq_o}, 8'h01);

        // R4 write with level high: bit 1 follows drive level
        @(negedge clk); drv_irq = 1'b1;
        wr(12'h202, 8'h00);
        rd(12'h202, 8'h02, "R4 keep flag bit");
        @(negedge clk); drv_irq = 1'b0;
        idle(1);

        // R8 socket/copy and unknown offsets
        wr(12'h206, 8'hFF);
        wr(12'h203, 8'hFF);
        wr(12'h208, 8'hFF);
        wr(12'h3FF, 8'hFF);
        rd(12'h206, 8'h00, "R8 socket zero");
        rd(12'h203, 8'h00, "R8 odd offset zero");
        rd(12'h2FF, 8'h00, "R8 far offset zero");
        rd(12'h200, 8'h01, "R8 option untouched");
        rd(12'h202, 8'h00, "R8 status untouched");
        rd(12'h204, 8'h2C, "R8 pin untouched");

        // R3 soft-reset hold
        wr(12'h202, 8'h30);
        rd(12'h202, 8'h30, "R4 before hold");
        wr(12'h200, 8'h81);
        check("R3 sreset high", {7'd0, sreset_o}, 8'h01);
        check("R10 irq off in hold", {7'd0, irq_o}, 8'h00);
        rd(12'h200, 8'h81, "R3 option stored");
        rd(12'h202, 8'h00, "R3 status cleared");
        rd(12'h204, 8'h0C, "R3 pin cleared");
        wr(12'h202, 8'h74);
        @(negedge clk); drv_irq = 1'b1;
        rd(12'h202, 8'h00, "R3 status held");
        @(negedge clk); drv_irq = 1'b0;
        wr(12'h200, 8'h00);
        check("R3 released", {7'd0, sreset_o}, 8'h00);
        check("R10 irq restored", {7'd0, irq_o}, 8'h01);
        check("R2 mode zero", {2'b0, mode_o}, 8'h00);
        rd(12'h204, 8'h0C, "R3 pin after release");

        idle(3);
        if (sb_q.size() != 0) begin
            n_vec++; n_bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule